// File: doc/BRIEF.md
# Serial Configuration Chain Shift Engine

This block lets software load long serial configuration chains that sit in several lanes. Software writes two registers. The setup register holds a clock-divide exponent, a route select and one bypass bit per lane. The command register holds a 32-bit shift word, a bit count, a lane select and two command bits. One command shifts 1 to 32 bits through the selected lane's chain on a divided serial clock and collects the bits that come out of it. A second kind of command sends one strobe that moves the chain contents into the lane's active configuration.

A full chain holds 1072 bits, so software loads or flushes a chain with a series of commands of up to 32 bits each. It polls the self-clearing command bit to see when each command has finished. The serial clock, data and strobe lines are plain control pins with no handshake. The lane clocks each chain on the rising edge of its serial clock, and the engine never stalls once a command has started.

Top module: `scan_shift_engine`

## Requirements
- R1: Reset is asynchronous and active low. It clears every field of both registers and returns the engine to idle, even in the middle of a command. After reset both command bits read 0 and all lane clock and strobe outputs are 0.
- R2: A write with `csr_wr_sel`=0 sets the setup register. The fields are: divide exponent E in bits [3:0], route select in bits [5:4] and the per-lane bypass mask in bits [11:8]. The register reads back with the same layout, and the route and bypass fields drive `cfg_route` and `cfg_bypass` directly.
- R3: One serial clock period lasts 2^(E+2) core cycles: a low half of 2^(E+1) cycles followed by a high half of the same length. The shift-busy bit stays at 1 for exactly N·2^(E+2) cycles after the write edge.
- R4: Command register bits [36:32] hold N−1. A shift command produces exactly N rising edges on the selected lane's serial clock.
- R5: `lane_tdi` presents bit 0 of the shift word for the first rising edge, then bit 1, and so on. It holds steady for the whole period around each rising edge.
- R6: At each rising edge the engine shifts the lane's output bit into bit 31 of the shift word. After N bits, (bits [31:0] >> (32−N)) gives the emerged bits, with bit 0 being the first bit out.
- R7: Writing 1 to bit 48 starts a shift. The bit reads 1 while the shift runs and clears itself when the shift ends.
- R8: Writing 1 to bit 49 (with bit 48 at 0) drives the selected lane's `lane_upd` high for 2^(E+1) cycles, and bit 49 reads 1 for 2^(E+2) cycles before it clears itself. If bits 48 and 49 are both written as 1, only the shift runs.
- R9: The lane select field in bits [43:40] is one-hot, with bit q selecting lane q. Serial clock edges and strobes reach only the selected lanes. With no lane selected, no clock line toggles and the shift captures zeros.
- R10: Any write to the command register while a shift or an update is busy is ignored. The running command ends exactly as it would have without the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr_en | input | 1 | Register write strobe |
| csr_wr_sel | input | 1 | Write target: 0 setup, 1 command |
| csr_wr_data | input | 64 | Write data |
| csr_rd_sel | input | 1 | Read source: 0 setup, 1 command |
| csr_rd_data | output | 64 | Read data (combinational) |
| lane_sclk | output | LANES | Serial clock, one line per lane |
| lane_tdi | output | 1 | Serial data into the chains |
| lane_tdo | input | LANES | Serial data out of each lane's chain |
| lane_upd | output | LANES | Update strobe, one line per lane |
| cfg_bypass | output | LANES | Per-lane bypass bits from the setup register |
| cfg_route | output | ROUTE_W | Route select from the setup register |

## Verification
The bench attaches behavioural 1072-bit chains to each lane. It runs a table of shifts that mix widths (1, partial and full 32-bit), divide exponents and lanes, and checks the captured words, the chain contents and the exact busy length. A design that captured after the lane had already shifted, or that reversed the bit order, would return the wrong word. An off-by-one in the count would show as an extra or missing clock edge.

Directed cases cover the following:
- A second command written in mid-shift, which a careless design would let retarget the lane or reload the count.
- A command with both command bits set, where a wrong design would also fire a strobe.
- A command with no lane selected, where a wrong design would toggle a lane clock.
- A 1072-bit round trip through a whole chain.
- A reset in mid-command, after which a wrong design would leave a busy bit stuck.

// File: rtl/sse_pkg.sv
package sse_pkg;
  localparam int REG_W         = 64;
  localparam int CFG_EXP_LSB   = 0;
  localparam int CFG_ROUTE_LSB = 4;
  localparam int CFG_BYP_LSB   = 8;
  localparam int DAT_CNT_LSB   = 32;
  localparam int DAT_SEL_LSB   = 40;
  localparam int DAT_SHIFT_BIT = 48;
  localparam int DAT_UPD_BIT   = 49;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLO,
    ST_SHI,
    ST_UHI,
    ST_ULO
  } seq_st_e;
endpackage

// File: rtl/sse_divider.sv
module sse_divider #(
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [EXP_W-1:0] exp_run,
  output logic             tick
);
  localparam int HALF_W = (1 << EXP_W) + 1;

  logic [HALF_W-1:0] cnt_q;
  logic [HALF_W-1:0] half_m1;

  assign half_m1 = (HALF_W'(1) << (int'(exp_run) + 1)) - HALF_W'(1);
  assign tick    = run && (cnt_q == half_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || tick)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + HALF_W'(1);
  end

  // R3: the half-period counter never passes its terminal count
  assert_div_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= half_m1);
endmodule

// File: rtl/sse_sequencer.sv
module sse_sequencer
  import sse_pkg::*;
#(
  parameter int WORD  = 32,
  parameter int EXP_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [WORD-1:0]          load_val,
  input  logic                     start_shift,
  input  logic                     start_upd,
  input  logic [EXP_W-1:0]         exp_in,
  input  logic [$clog2(WORD)-1:0]  nm1,
  input  logic                     tick,
  input  logic                     tdo_bit,
  output logic [WORD-1:0]          shreg,
  output logic                     tdi,
  output logic [EXP_W-1:0]         exp_run,
  output logic                     shift_busy,
  output logic                     upd_busy,
  output logic                     sclk_on,
  output logic                     upd_on
);
  localparam int CNT_W = $clog2(WORD);

  seq_st_e          st_q;
  logic [CNT_W-1:0] bit_idx;

  assign shift_busy = (st_q == ST_SLO) || (st_q == ST_SHI);
  assign upd_busy   = (st_q == ST_UHI) || (st_q == ST_ULO);
  assign sclk_on    = (st_q == ST_SHI);
  assign upd_on     = (st_q == ST_UHI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      shreg   <= '0;
      tdi     <= 1'b0;
      bit_idx <= '0;
      exp_run <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (load) shreg <= load_val;
          if (start_shift) begin
            st_q    <= ST_SLO;
            tdi     <= load_val[0];
            bit_idx <= '0;
            exp_run <= exp_in;
          end else if (start_upd) begin
            st_q    <= ST_UHI;
            exp_run <= exp_in;
          end
        end
        ST_SLO: if (tick) begin
          st_q  <= ST_SHI;
          shreg <= {tdo_bit, shreg[WORD-1:1]};
        end
        ST_SHI: if (tick) begin
          if (bit_idx == nm1) begin
            st_q <= ST_IDLE;
          end else begin
            st_q    <= ST_SLO;
            bit_idx <= bit_idx + CNT_W'(1);
            tdi     <= shreg[0];
          end
        end
        ST_UHI: if (tick) st_q <= ST_ULO;
        ST_ULO: if (tick) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R4: a shift only finishes after its final counted bit
  assert_last_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shift_busy) |-> $past(bit_idx == nm1));

  // R5: serial data stays steady across the rising clock edge
  assert_tdi_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SHI) |-> $stable(tdi));
endmodule

// File: rtl/sse_lane_fanout.sv
module sse_lane_fanout #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] sel,
  input  logic             sclk_on,
  input  logic             upd_on,
  input  logic [LANES-1:0] lane_tdo,
  output logic [LANES-1:0] lane_sclk,
  output logic [LANES-1:0] lane_upd,
  output logic             tdo_bit
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_sclk[g] = sclk_on & sel[g];
    assign lane_upd[g]  = upd_on & sel[g];
  end

  assign tdo_bit = |(lane_tdo & sel);

  // R9: only selected lanes see clock or strobe
  assert_lane_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((lane_sclk | lane_upd) & ~sel) == '0);

  // R8: strobe and serial clock are never active together
  assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !((|lane_sclk) && (|lane_upd)));
endmodule

// File: rtl/scan_shift_engine.sv
module scan_shift_engine
  import sse_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int WORD    = 32,
  parameter int EXP_W   = 4,
  parameter int ROUTE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csr_wr_en,
  input  logic               csr_wr_sel,
  input  logic [63:0]        csr_wr_data,
  input  logic               csr_rd_sel,
  output logic [63:0]        csr_rd_data,
  output logic [LANES-1:0]   lane_sclk,
  output logic               lane_tdi,
  input  logic [LANES-1:0]   lane_tdo,
  output logic [LANES-1:0]   lane_upd,
  output logic [LANES-1:0]   cfg_bypass,
  output logic [ROUTE_W-1:0] cfg_route
);
  localparam int CNT_W = $clog2(WORD);

  logic [EXP_W-1:0]   exp_q;
  logic [ROUTE_W-1:0] route_q;
  logic [LANES-1:0]   byp_q;
  logic [LANES-1:0]   sel_q;
  logic [CNT_W-1:0]   cnt_q;

  logic [WORD-1:0]    shreg;
  logic [EXP_W-1:0]   exp_run;
  logic shift_busy, upd_busy, sclk_on, upd_on, tick, tdo_bit;
  logic busy, data_wr, start_shift, start_upd;
  logic unused_wdata;

  assign busy        = shift_busy | upd_busy;
  assign data_wr     = csr_wr_en & csr_wr_sel & ~busy;
  assign start_shift = data_wr & csr_wr_data[DAT_SHIFT_BIT];
  assign start_upd   = data_wr & csr_wr_data[DAT_UPD_BIT] & ~csr_wr_data[DAT_SHIFT_BIT];
  assign unused_wdata = ^csr_wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q   <= '0;
      route_q <= '0;
      byp_q   <= '0;
      sel_q   <= '0;
      cnt_q   <= '0;
    end else begin
      if (csr_wr_en && !csr_wr_sel) begin
        exp_q   <= csr_wr_data[CFG_EXP_LSB +: EXP_W];
        route_q <= csr_wr_data[CFG_ROUTE_LSB +: ROUTE_W];
        byp_q   <= csr_wr_data[CFG_BYP_LSB +: LANES];
      end
      if (data_wr) begin
        sel_q <= csr_wr_data[DAT_SEL_LSB +: LANES];
        cnt_q <= csr_wr_data[DAT_CNT_LSB +: CNT_W];
      end
    end
  end

  always_comb begin
    csr_rd_data = '0;
    if (!csr_rd_sel) begin
      csr_rd_data[CFG_EXP_LSB +: EXP_W]     = exp_q;
      csr_rd_data[CFG_ROUTE_LSB +: ROUTE_W] = route_q;
      csr_rd_data[CFG_BYP_LSB +: LANES]     = byp_q;
    end else begin
      csr_rd_data[WORD-1:0]                 = shreg;
      csr_rd_data[DAT_CNT_LSB +: CNT_W]     = cnt_q;
      csr_rd_data[DAT_SEL_LSB +: LANES]     = sel_q;
      csr_rd_data[DAT_SHIFT_BIT]            = shift_busy;
      csr_rd_data[DAT_UPD_BIT]              = upd_busy;
    end
  end

  assign cfg_bypass = byp_q;
  assign cfg_route  = route_q;

  sse_divider #(.EXP_W(EXP_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .exp_run(exp_run), .tick(tick)
  );

  sse_sequencer #(.WORD(WORD), .EXP_W(EXP_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .load(data_wr), .load_val(csr_wr_data[WORD-1:0]),
    .start_shift(start_shift), .start_upd(start_upd),
    .exp_in(exp_q), .nm1(cnt_q), .tick(tick), .tdo_bit(tdo_bit),
    .shreg(shreg), .tdi(lane_tdi), .exp_run(exp_run),
    .shift_busy(shift_busy), .upd_busy(upd_busy),
    .sclk_on(sclk_on), .upd_on(upd_on)
  );

  sse_lane_fanout #(.LANES(LANES)) u_fan (
    .clk(clk), .rst_n(rst_n), .sel(sel_q),
    .sclk_on(sclk_on), .upd_on(upd_on), .lane_tdo(lane_tdo),
    .lane_sclk(lane_sclk), .lane_upd(lane_upd), .tdo_bit(tdo_bit)
  );

  // R10: a command-register write during a busy command changes nothing
  assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && csr_wr_en && csr_wr_sel) |=> ($stable(sel_q) && $stable(cnt_q)));

  // R7: a shift command is visible as busy on the following cycle
  assert_shift_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && csr_wr_en && csr_wr_sel && csr_wr_data[DAT_SHIFT_BIT]) |=> shift_busy);
endmodule

// File: tb/tb_scan_shift_engine.sv
`timescale 1ns/1ps
module tb_scan_shift_engine;
  localparam int LANES = 4;
  localparam int CH    = 1072;
  localparam int CAP   = 70000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csr_wr_en = 1'b0, csr_wr_sel = 1'b0, csr_rd_sel = 1'b1;
  logic [63:0] csr_wr_data = '0;
  logic [63:0] csr_rd_data;
  logic [LANES-1:0] lane_sclk, lane_tdo, lane_upd, cfg_bypass;
  logic lane_tdi;
  logic [1:0] cfg_route;

  always #2.5 clk = ~clk;

  scan_shift_engine dut (
    .clk(clk), .rst_n(rst_n), .csr_wr_en(csr_wr_en), .csr_wr_sel(csr_wr_sel),
    .csr_wr_data(csr_wr_data), .csr_rd_sel(csr_rd_sel), .csr_rd_data(csr_rd_data),
    .lane_sclk(lane_sclk), .lane_tdi(lane_tdi), .lane_tdo(lane_tdo),
    .lane_upd(lane_upd), .cfg_bypass(cfg_bypass), .cfg_route(cfg_route)
  );

  // behavioural lane chains
  logic seed = 1'b0;
  logic [CH-1:0] chain [LANES];
  logic [CH-1:0] act   [LANES];
  int sclk_cnt [LANES];
  int upd_cnt  [LANES];

  function automatic logic [CH-1:0] pat(int g);
    logic [CH-1:0] p;
    for (int b = 0; b < CH; b++) p[b] = ((b * 5 + g * 3) % 7) < 3;
    return p;
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_model
    always @(posedge lane_sclk[g] or posedge seed) begin
      if (seed) chain[g] <= pat(g);
      else begin
        chain[g] <= {lane_tdi, chain[g][CH-1:1]};
        sclk_cnt[g]++;
      end
    end
    always @(posedge lane_upd[g]) begin
      act[g] <= chain[g];
      upd_cnt[g]++;
    end
    assign lane_tdo[g] = chain[g][0];
  end

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] a, input logic [63:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  function automatic logic [63:0] dword(logic [3:0] sel, int n, logic [31:0] d, bit sh, bit up);
    logic [63:0] w;
    w = '0;
    w[31:0]  = d;
    w[36:32] = 5'(n - 1);
    w[43:40] = sel;
    w[48]    = sh;
    w[49]    = up;
    return w;
  endfunction

  task automatic wr(input logic s, input logic [63:0] v);
    @(negedge clk);
    csr_wr_en = 1'b1; csr_wr_sel = s; csr_wr_data = v;
    @(negedge clk);
    csr_wr_en = 1'b0;
  endtask

  task automatic wait_busy(input int bitpos, output int cyc);
    csr_rd_sel = 1'b1;
    cyc = 0;
    while (csr_rd_data[bitpos] && cyc < CAP) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic do_shift(input logic [3:0] sel, input int n, input logic [31:0] d,
                          input int e, output logic [31:0] rb, output int cyc);
    wr(1'b0, 64'(e));
    wr(1'b1, dword(sel, n, d, 1'b1, 1'b0));
    wait_busy(48, cyc);
    rb = csr_rd_data[31:0];
  endtask

  typedef struct packed {
    logic [3:0]  lane;
    logic [5:0]  n;
    logic [3:0]  e;
    logic [31:0] d;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'b0001, 6'd32, 4'd0, 32'hA5C3_0F96},
    '{4'b0010, 6'd1,  4'd1, 32'h0000_0001},
    '{4'b0100, 6'd7,  4'd0, 32'h0000_005A},
    '{4'b1000, 6'd16, 4'd2, 32'h0000_C3E1},
    '{4'b0001, 6'd31, 4'd0, 32'h7FED_1234},
    '{4'b0010, 6'd3,  4'd1, 32'h0000_0006},
    '{4'b0100, 6'd32, 4'd0, 32'hFFFF_0000},
    '{4'b1000, 6'd12, 4'd0, 32'h0000_0ABC}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [31:0] rb, expo;
    logic [CH-1:0] old, expn;
    logic [CH-1:0] act_old [LANES];
    int snap [LANES];
    int usnap [LANES];
    int cyc, li, n, e, hi;

    for (int g = 0; g < LANES; g++) begin sclk_cnt[g] = 0; upd_cnt[g] = 0; end
    #1 seed = 1'b1;
    #1 seed = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    csr_rd_sel = 1'b0; #0.1;
    check(csr_rd_data == 64'd0, "R1 setup reg after reset", csr_rd_data, 0);
    csr_rd_sel = 1'b1; #0.1;
    check(csr_rd_data == 64'd0, "R1 command reg after reset", csr_rd_data, 0);
    check(lane_sclk == 0 && lane_upd == 0, "R1 lane outputs idle", {lane_sclk, lane_upd}, 0);

    // R2 setup register layout and pins
    wr(1'b0, 64'h0000_0A23);
    csr_rd_sel = 1'b0; #0.1;
    check(csr_rd_data == 64'h0000_0A23, "R2 setup readback", csr_rd_data, 64'h0A23);
    check(cfg_bypass == 4'b1010 && cfg_route == 2'd2, "R2 bypass/route pins",
          {cfg_bypass, cfg_route}, {4'b1010, 2'd2});
    csr_rd_sel = 1'b1;

    // table of shifts: R3 R4 R5 R6 R7 R9
    for (int i = 0; i < 8; i++) begin
      n = int'(VECS[i].n);
      e = int'(VECS[i].e);
      li = 0;
      for (int k = 0; k < LANES; k++) if (VECS[i].lane[k]) li = k;
      old = chain[li];
      for (int k = 0; k < LANES; k++) snap[k] = sclk_cnt[k];
      expo = '0;
      for (int b = 0; b < n; b++) expo[b] = old[b];
      for (int b = 0; b < CH; b++)
        expn[b] = (b >= CH - n) ? VECS[i].d[b - (CH - n)] : old[b + n];
      do_shift(VECS[i].lane, n, VECS[i].d, e, rb, cyc);
      check((rb >> (32 - n)) == expo, $sformatf("R6 captured word vec%0d", i), rb >> (32 - n), expo);
      check(cyc == n * (1 << (e + 2)), $sformatf("R3 busy length vec%0d", i), cyc, n * (1 << (e + 2)));
      check(sclk_cnt[li] - snap[li] == n, $sformatf("R4 clock edges vec%0d", i), sclk_cnt[li] - snap[li], n);
      check(csr_rd_data[36:32] == 5'(n - 1), $sformatf("R4 count field vec%0d", i), csr_rd_data[36:32], n - 1);
      check(chain[li] == expn, $sformatf("R5 chain contents vec%0d", i), chain[li][CH-1 -: 64], expn[CH-1 -: 64]);
      check(csr_rd_data[48] == 1'b0, $sformatf("R7 shift bit cleared vec%0d", i), csr_rd_data[48], 0);
      for (int k = 0; k < LANES; k++)
        if (k != li)
          check(sclk_cnt[k] == snap[k], $sformatf("R9 other lane %0d quiet vec%0d", k, i), sclk_cnt[k] - snap[k], 0);
    end

    // R10 write during busy is ignored
    wr(1'b0, 64'd1);
    old = chain[0];
    for (int k = 0; k < LANES; k++) snap[k] = sclk_cnt[k];
    expo = '0;
    for (int b = 0; b < 8; b++) expo[b] = old[b];
    wr(1'b1, dword(4'b0001, 8, 32'h0000_00B6, 1'b1, 1'b0));
    cyc = 0;
    while (csr_rd_data[48] && cyc < CAP) begin
      cyc++;
      if (cyc == 5) begin
        csr_wr_en = 1'b1; csr_wr_sel = 1'b1;
        csr_wr_data = dword(4'b0100, 20, 32'hFFFF_FFFF, 1'b1, 1'b1);
      end else csr_wr_en = 1'b0;
      @(negedge clk);
    end
    csr_wr_en = 1'b0;
    check(cyc == 64, "R10 busy length unchanged", cyc, 64);
    check((csr_rd_data[31:0] >> 24) == expo, "R10 captured word unchanged", csr_rd_data[31:0] >> 24, expo);
    check(csr_rd_data[43:40] == 4'b0001 && csr_rd_data[36:32] == 5'd7, "R10 select/count unchanged",
          csr_rd_data[43:32], {4'b0001, 3'b0, 5'd7});
    check(sclk_cnt[2] == snap[2] && sclk_cnt[0] - snap[0] == 8, "R10 only original lane clocked",
          sclk_cnt[2] - snap[2], 0);

    // R8 update strobe
    wr(1'b0, 64'd0);
    for (int k = 0; k < LANES; k++) begin usnap[k] = upd_cnt[k]; act_old[k] = act[k]; end
    wr(1'b1, dword(4'b0100, 1, 32'd0, 1'b0, 1'b1));
    cyc = 0; hi = 0;
    while (csr_rd_data[49] && cyc < CAP) begin
      cyc++;
      if (lane_upd[2]) hi++;
      @(negedge clk);
    end
    check(cyc == 4, "R8 update busy length", cyc, 4);
    check(hi == 2, "R8 strobe high length", hi, 2);
    check(upd_cnt[2] - usnap[2] == 1, "R8 one strobe on lane 2", upd_cnt[2] - usnap[2], 1);
    check(act[2] == chain[2], "R8 lane 2 active config loaded", act[2][63:0], chain[2][63:0]);
    for (int k = 0; k < LANES; k++)
      if (k != 2)
        check(upd_cnt[k] == usnap[k] && act[k] == act_old[k], $sformatf("R9 lane %0d no strobe", k),
              upd_cnt[k] - usnap[k], 0);
    check(csr_rd_data[49] == 1'b0, "R8 update bit cleared", csr_rd_data[49], 0);

    // R8 both command bits: shift wins
    for (int k = 0; k < LANES; k++) usnap[k] = upd_cnt[k];
    wr(1'b1, dword(4'b0010, 4, 32'h0000_0009, 1'b1, 1'b1));
    wait_busy(48, cyc);
    check(cyc == 16, "R8 both bits runs the shift", cyc, 16);
    check(upd_cnt[1] == usnap[1] && csr_rd_data[49] == 1'b0, "R8 both bits sends no strobe",
          upd_cnt[1] - usnap[1], 0);

    // R9 no lane selected
    for (int k = 0; k < LANES; k++) snap[k] = sclk_cnt[k];
    do_shift(4'b0000, 5, 32'h0000_001F, 0, rb, cyc);
    check((rb >> 27) == 0, "R9 no lane captures zeros", rb >> 27, 0);
    check(cyc == 20, "R9 no lane busy length", cyc, 20);
    hi = 0;
    for (int k = 0; k < LANES; k++) hi += sclk_cnt[k] - snap[k];
    check(hi == 0, "R9 no lane clock toggles", hi, 0);

    // R6 full-chain round trip on lane 3
    do_shift(4'b1000, 32, 32'h5EED_C0DE, 0, rb, cyc);
    for (int j = 0; j < 33; j++) do_shift(4'b1000, (j < 32) ? 32 : 16, 32'd0, 0, rb, cyc);
    do_shift(4'b1000, 32, 32'd0, 0, rb, cyc);
    check(rb == 32'h5EED_C0DE, "R6 word returns after 1072 bits", rb, 32'h5EED_C0DE);
    check(chain[3] == '0, "R6 chain flushed to zeros", chain[3][63:0], 0);

    // R1 reset in mid-command
    wr(1'b0, 64'd1);
    wr(1'b1, dword(4'b0001, 32, 32'h1234_5678, 1'b1, 1'b0));
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    csr_rd_sel = 1'b1; #0.1;
    check(csr_rd_data == 64'd0, "R1 mid-command reset clears", csr_rd_data, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(csr_rd_data[49:48] == 2'b00 && lane_sclk == 0, "R1 idle after reset release",
          {csr_rd_data[49:48], lane_sclk}, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule